// File: doc/BRIEF.md
# Predicated Vector Step Iterator

This block holds one vector loop cursor. The cursor is an element index and a sub-element index. Each advance request moves the cursor one position through a two-level loop. The outer and inner levels are bounded by a stored vector length and a sub-vector length. Software picks the nesting order at run time with an order flag. With the flag clear, the sub-element index is the inner loop. With it set, the element index is the inner loop. When the skip flag is set, the element index passes over positions whose predicate bit is 0. This scan costs one clock per element visited, so one advance can move the element index by more than one.

One instance serves the source side and a second identical instance serves the destination side. They are wired to their own order flag and predicate. When an advance finishes, the block pulses `done` for one cycle. `loop_end` is raised with it when both loops are exhausted.

The vector length is a count from 1 to 64. The sub-vector field gives the largest sub-element index, from 0 to 3. Both settings, and the order and skip flags, are held stable while an advance is in progress.

Top module: `step_iter`

## Requirements
- R1: After synchronous reset, `step` and `substep` are 0, and `busy`, `done` and `loop_end` are 0.
- R2: With `order_inv`=0 and `substep` below `subvl`, an advance sets `substep` to `substep`+1 and leaves `step` unchanged. It completes in one clock, with `done` high in the cycle after the request.
- R3: With `order_inv`=0 and `substep` equal to `subvl`, an advance sets `substep` to 0 and advances `step`.
- R4: With `order_inv`=0, when the advance finds `step` at `vl`-1, `step` and `substep` both become 0 and `loop_end` is high together with `done`.
- R5: With `order_inv`=1 and `step` below `vl`-1, an advance increments `step` and leaves `substep` unchanged.
- R6: With `order_inv`=1, `step` at `vl`-1 and `substep` below `subvl`, an advance sets `step` to 0 and increments `substep`. `loop_end` stays 0.
- R7: With `order_inv`=1, `step` at `vl`-1 and `substep` equal to `subvl`, an advance raises `loop_end` with `done`, and `step` and `substep` keep their values.
- R8: With `zero_skip`=0, every element advance moves `step` by exactly one, whatever `pred_mask` holds.
- R9: With `zero_skip`=1, the element index keeps moving, one position per clock, until it lands on a position whose `pred_mask` bit is 1. If it reaches `vl`-1 without one, the end-of-loop rule of R4, R6 or R7 applies. Bit i of `pred_mask` belongs to element i. `busy` is high on every scan clock after the first, `step` rises by one on each, and `done` marks the final clock.
- R10: `step` never exceeds `vl`-1, and `substep` never exceeds `subvl`.
- R11: An `adv_req` that arrives while `busy` is high is ignored.
- R12: `loop_end` is never high unless `done` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_req | input | 1 | Request one cursor advance |
| vl | input | 7 | Vector length, 1 to 64 |
| subvl | input | 2 | Largest sub-element index |
| order_inv | input | 1 | 1 makes the element index the inner loop |
| zero_skip | input | 1 | 1 skips elements whose predicate bit is 0 |
| pred_mask | input | 64 | Predicate, bit i for element i |
| step | output | 6 | Current element index |
| substep | output | 2 | Current sub-element index |
| busy | output | 1 | Predicate scan in progress |
| done | output | 1 | One-cycle pulse when an advance completes |
| loop_end | output | 1 | Both loops exhausted, valid with done |

## Verification
Two events can fall on the same clock. One is the sub-element wrap or increment. The other is the element index hitting `vl`-1, which ends or wraps the whole loop. In both orders the bench drives the cursor to `vl`-1 with the sub-index at and below its limit. It also sends a predicate scan that runs into the end position with no set bit left, so the scan's final clock coincides with the loop end. A behavioural model, computing each advance as a whole, checks the output on every clock. It checks the `busy` length, the `done` and `loop_end` cycles, and the final indices, including requests held high through a scan.

// File: rtl/step_iter_pkg.sv
package step_iter_pkg;
    parameter int unsigned MAX_VL = 64;
    parameter int unsigned SUB_W  = 2;
    localparam int unsigned STEP_W = $clog2(MAX_VL);
    localparam int unsigned VL_W   = $clog2(MAX_VL + 1);

    typedef logic [STEP_W-1:0] step_t;
    typedef logic [SUB_W-1:0]  sub_t;
    typedef logic [VL_W-1:0]   vlen_t;
    typedef logic [MAX_VL-1:0] pmask_t;

    typedef enum logic {ST_IDLE, ST_SCAN} iter_st_e;

    typedef struct packed {
        step_t step;
        sub_t  sub;
        logic  finish;
        logic  lend;
    } iter_res_t;

    function automatic logic is_last(step_t s, vlen_t len);
        return vlen_t'(s) == (len - vlen_t'(1));
    endfunction
endpackage

// File: rtl/step_iter_next.sv
module step_iter_next
    import step_iter_pkg::*;
(
    input  step_t     cur_step,
    input  sub_t      cur_sub,
    input  vlen_t     vl,
    input  sub_t      subvl,
    input  logic      order_inv,
    input  logic      zero_skip,
    input  pmask_t    pred_mask,
    input  logic      first,
    output iter_res_t res
);
    logic  at_last;
    logic  sub_full;
    step_t inc_step;

    always_comb begin
        at_last  = is_last(cur_step, vl);
        sub_full = (cur_sub == subvl);
        inc_step = cur_step + step_t'(1);

        res.step   = cur_step;
        res.sub    = cur_sub;
        res.finish = 1'b0;
        res.lend   = 1'b0;

        if (first && !order_inv && !sub_full) begin
            res.sub    = cur_sub + sub_t'(1);
            res.finish = 1'b1;
        end else if (at_last) begin
            res.finish = 1'b1;
            if (order_inv) begin
                if (!sub_full) begin
                    res.sub  = cur_sub + sub_t'(1);
                    res.step = '0;
                end else begin
                    res.lend = 1'b1;
                end
            end else begin
                res.step = '0;
                res.sub  = '0;
                res.lend = 1'b1;
            end
        end else begin
            res.step   = inc_step;
            if (!order_inv) res.sub = '0;
            res.finish = !zero_skip || pred_mask[inc_step];
        end
    end
endmodule

// File: rtl/step_iter_ctrl.sv
module step_iter_ctrl
    import step_iter_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      adv_req,
    input  iter_res_t res,
    output logic      first,
    output step_t     step_q,
    output sub_t      sub_q,
    output logic      busy,
    output logic      done_q,
    output logic      lend_q
);
    iter_st_e state;
    logic     fire;

    always_comb begin
        first = (state == ST_IDLE);
        fire  = (state == ST_SCAN) || adv_req;
        busy  = (state == ST_SCAN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            step_q <= '0;
            sub_q  <= '0;
            done_q <= 1'b0;
            lend_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            lend_q <= 1'b0;
            if (fire) begin
                step_q <= res.step;
                sub_q  <= res.sub;
                if (res.finish) begin
                    state  <= ST_IDLE;
                    done_q <= 1'b1;
                    lend_q <= res.lend;
                end else begin
                    state  <= ST_SCAN;
                end
            end
        end
    end
endmodule

// File: rtl/step_iter.sv
module step_iter
    import step_iter_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              adv_req,
    input  logic [VL_W-1:0]   vl,
    input  logic [SUB_W-1:0]  subvl,
    input  logic              order_inv,
    input  logic              zero_skip,
    input  logic [MAX_VL-1:0] pred_mask,
    output logic [STEP_W-1:0] step,
    output logic [SUB_W-1:0]  substep,
    output logic              busy,
    output logic              done,
    output logic              loop_end
);
    iter_res_t res;
    logic      first;

    step_iter_next u_next (
        .cur_step  (step),
        .cur_sub   (substep),
        .vl        (vl),
        .subvl     (subvl),
        .order_inv (order_inv),
        .zero_skip (zero_skip),
        .pred_mask (pred_mask),
        .first     (first),
        .res       (res)
    );

    step_iter_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .adv_req (adv_req),
        .res     (res),
        .first   (first),
        .step_q  (step),
        .sub_q   (substep),
        .busy    (busy),
        .done_q  (done),
        .lend_q  (loop_end)
    );
endmodule

// File: rtl/step_iter_chk.sv
module step_iter_chk
    import step_iter_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [VL_W-1:0]   vl,
    input logic [SUB_W-1:0]  subvl,
    input logic [STEP_W-1:0] step,
    input logic [SUB_W-1:0]  substep,
    input logic              busy,
    input logic              done,
    input logic              loop_end
);
    p_step_bound_r10: assert property (@(posedge clk) disable iff (rst)
        vlen_t'(step) < vl);

    p_sub_bound_r10: assert property (@(posedge clk) disable iff (rst)
        substep <= subvl);

    p_lend_needs_done_r12: assert property (@(posedge clk) disable iff (rst)
        loop_end |-> done);

    p_scan_one_per_clk_r9: assert property (@(posedge clk) disable iff (rst)
        busy |=> (done || step == step_t'($past(step) + 1'b1)));

    p_scan_sub_stable_r9: assert property (@(posedge clk) disable iff (rst)
        busy |=> (done || $stable(substep)));

    p_no_done_while_busy_r11: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done);
endmodule

bind step_iter step_iter_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .vl       (vl),
    .subvl    (subvl),
    .step     (step),
    .substep  (substep),
    .busy     (busy),
    .done     (done),
    .loop_end (loop_end)
);

// File: tb/step_iter_test.sv
`timescale 1ns/1ps
module step_iter_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        adv_req = 1'b0;
    logic [6:0]  vl = 7'd4;
    logic [1:0]  subvl = 2'd0;
    logic        order_inv = 1'b0;
    logic        zero_skip = 1'b0;
    logic [63:0] pred_mask = '0;
    logic [5:0]  step;
    logic [1:0]  substep;
    logic        busy, done, loop_end;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit summary_done = 0;

    // reference model state
    int  m_step = 0, m_sub = 0, pend = 0;
    int  f_step = 0, f_sub = 0;
    bit  f_lend = 0;
    bit  e_busy = 0, e_done = 0, e_lend = 0;

    always #2 clk = ~clk;

    step_iter uut (
        .clk(clk), .rst(rst), .adv_req(adv_req), .vl(vl), .subvl(subvl),
        .order_inv(order_inv), .zero_skip(zero_skip), .pred_mask(pred_mask),
        .step(step), .substep(substep), .busy(busy), .done(done), .loop_end(loop_end)
    );

    // Whole-advance computation: returns clocks used, final indices, end flag
    task automatic plan_adv(output int n, output int s, output int u, output bit le);
        int len = int'(vl);
        int lim = int'(subvl);
        s = m_step; u = m_sub; le = 0; n = 0;
        if (!order_inv && u != lim) begin
            u = u + 1; n = 1;
            return;
        end
        if (!order_inv) u = 0;
        forever begin
            n = n + 1;
            if (s == len - 1) begin
                if (order_inv) begin
                    if (u != lim) begin u = u + 1; s = 0; end
                    else le = 1;
                end else begin
                    s = 0; u = 0; le = 1;
                end
                break;
            end
            s = s + 1;
            if (!zero_skip || pred_mask[s]) break;
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            m_step = 0; m_sub = 0; pend = 0;
            e_busy = 0; e_done = 0; e_lend = 0;
        end else begin
            e_done = 0; e_lend = 0;
            if (pend > 0) begin
                pend = pend - 1;
                if (pend == 0) begin
                    m_step = f_step; m_sub = f_sub;
                    e_done = 1; e_lend = f_lend;
                end
            end else if (adv_req) begin
                int n;
                plan_adv(n, f_step, f_sub, f_lend);
                if (n == 1) begin
                    m_step = f_step; m_sub = f_sub;
                    e_done = 1; e_lend = f_lend;
                end else begin
                    pend = n - 1;
                end
            end
            e_busy = (pend > 0);
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            chk("R9,R11", "busy", int'(busy), int'(e_busy));
            chk("R2,R9", "done", int'(done), int'(e_done));
            chk("R4,R6,R7,R12", "loop_end", int'(loop_end), int'(e_lend));
            if (!e_busy) begin
                chk("R3,R5,R8,R10", "step", int'(step), m_step);
                chk("R2,R6,R7", "substep", int'(substep), m_sub);
            end
        end
    end

    task automatic setup(input int len, input int lim, input bit inv, input bit zs, input logic [63:0] m);
        @(negedge clk);
        rst = 1;
        vl = 7'(len); subvl = 2'(lim); order_inv = inv; zero_skip = zs; pred_mask = m;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
    endtask

    task automatic adv(input int count);
        for (int i = 0; i < count; i++) begin
            @(negedge clk);
            adv_req = 1;
            @(negedge clk);
            adv_req = 0;
            while (busy) @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "step", int'(step), 0);
        chk("R1", "substep", int'(substep), 0);
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "done", int'(done), 0);
        chk("R1", "loop_end", int'(loop_end), 0);
        rst = 0;

        // R2 R3 R4: normal order, full pass plus wrap
        setup(3, 1, 0, 0, 64'h0);
        adv(8);

        // R5 R6 R7: inverted order, run to end and hold
        setup(3, 2, 1, 0, 64'h0);
        adv(11);

        // R8: no skipping even with empty predicate
        setup(5, 0, 0, 0, 64'h0);
        adv(6);

        // R9: skipping in normal order, ends in scan reaching last element
        setup(10, 0, 0, 1, 64'h211);
        adv(5);

        // R9 R6 R7: skipping in inverted order
        setup(8, 1, 1, 1, 64'h20);
        adv(6);

        // R10: single-element vector
        setup(1, 2, 1, 0, 64'h0);
        adv(4);
        setup(1, 1, 0, 1, 64'h0);
        adv(4);

        // R9: longest scan to element 63 and beyond
        setup(64, 0, 0, 1, 64'h8000_0000_0000_0000);
        adv(3);

        // R11: request held high through scans
        setup(16, 1, 1, 1, 64'h0101);
        @(negedge clk);
        adv_req = 1;
        repeat (60) @(negedge clk);
        adv_req = 0;
        repeat (20) @(negedge clk);

        // R2 R3: back-to-back requests in normal order
        setup(4, 3, 0, 0, 64'h0);
        @(negedge clk);
        adv_req = 1;
        repeat (25) @(negedge clk);
        adv_req = 0;
        repeat (4) @(negedge clk);

        finish_run();
    end
endmodule